// File: doc/BRIEF.md
# Vector Register Elementwise Sequencer

This block holds a file of vector registers and runs one elementwise integer operation across every element of a register per command. A command names two source registers, a destination register and an operation code. Once the command is accepted, the sequencer generates the element index itself. It walks the elements from first to last, one per clock, and writes each result back to the destination.

A scalar port lets the surrounding logic load any single element while the sequencer is idle, and read any element back with one cycle of latency. The port is used to load operands before a command and to collect results after it. Commands that arrive while a run is in progress are refused. A command that carries an unsupported operation code writes nothing and completes at once with an error indication.

The defaults are eight registers of 64 elements, each element 64 bits wide, with a 7-bit operation field.

Top module: `vec_seq`

## Requirements
- R1: After reset, busy, done and err are low, issue_ready is high and sc_rdata is zero.
- R2: While idle, a cycle with sc_we high stores sc_wdata into element sc_idx of register sc_reg. sc_rdata shows the element addressed by sc_reg and sc_idx at the previous clock edge.
- R3: The supported operation codes are 7'h01 (add), 7'h02 (subtract, src_a minus src_b, modulo 2^64), 7'h03 (bitwise AND), 7'h04 (bitwise OR) and 7'h05 (bitwise XOR). Each element i of the destination becomes op(src_a[i], src_b[i]) for every i from 0 to 63.
- R4: A command with a supported code is accepted on an edge where issue_valid and issue_ready are both high. busy then stays high for exactly 64 cycles. done is high for exactly one cycle: the first cycle in which busy is low again.
- R5: issue_ready is the inverse of busy. A command offered while busy is ignored: no register other than the running destination changes, and the running command still ends 64 cycles after its acceptance.
- R6: The destination may be the same register as either source, or as both. The result is the same as if all sources had been read before any write.
- R7: A command with an unsupported code writes no element and leaves busy low. done and err are both high for one cycle, in the cycle after acceptance. err is low when a supported command completes.
- R8: A scalar write attempted while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue_valid | input | 1 | A command is offered |
| issue_ready | output | 1 | A command can be accepted |
| issue_op | input | 7 | Operation code |
| issue_dst | input | 3 | Destination register |
| issue_src_a | input | 3 | First source register |
| issue_src_b | input | 3 | Second source register |
| busy | output | 1 | Sequencer is stepping through elements |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | The completed command had an unsupported code |
| sc_we | input | 1 | Scalar element write enable |
| sc_reg | input | 3 | Scalar access register select |
| sc_idx | input | 6 | Scalar access element index |
| sc_wdata | input | 64 | Scalar write data |
| sc_rdata | output | 64 | Scalar read data, one cycle latency |

## Verification
The assertions assume that reset is applied before the first command. They also assume that the command and scalar inputs hold steady from one falling edge to the next, so that every rising edge samples settled values. The bench changes all inputs only on falling edges. It deliberately offers commands and scalar writes while busy, because the design must tolerate them. The checks on element values rely on a model in the bench that is updated only by accepted commands and idle scalar writes.

// File: rtl/vec_seq.sv
module vec_seq #(
  parameter int NREG  = 8,
  parameter int NELEM = 64,
  parameter int W     = 64,
  parameter int OPW   = 7,
  localparam int RW   = $clog2(NREG),
  localparam int IW   = $clog2(NELEM)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           issue_valid,
  output logic           issue_ready,
  input  logic [OPW-1:0] issue_op,
  input  logic [RW-1:0]  issue_dst,
  input  logic [RW-1:0]  issue_src_a,
  input  logic [RW-1:0]  issue_src_b,
  output logic           busy,
  output logic           done,
  output logic           err,
  input  logic           sc_we,
  input  logic [RW-1:0]  sc_reg,
  input  logic [IW-1:0]  sc_idx,
  input  logic [W-1:0]   sc_wdata,
  output logic [W-1:0]   sc_rdata
);

  localparam logic [OPW-1:0] OP_ADD = OPW'(1);
  localparam logic [OPW-1:0] OP_SUB = OPW'(2);
  localparam logic [OPW-1:0] OP_AND = OPW'(3);
  localparam logic [OPW-1:0] OP_OR  = OPW'(4);
  localparam logic [OPW-1:0] OP_XOR = OPW'(5);
  localparam logic [IW-1:0]  LAST   = IW'(NELEM - 1);

  logic [W-1:0]   vrf [NREG*NELEM];
  logic [OPW-1:0] op_q;
  logic [RW-1:0]  dst_q, a_q, b_q;
  logic [IW-1:0]  idx_q;
  logic           busy_q, done_q, err_q;
  logic [W-1:0]   rd_q;
  logic [W-1:0]   res;

  function automatic logic op_known(input logic [OPW-1:0] op);
    return op == OP_ADD || op == OP_SUB || op == OP_AND ||
           op == OP_OR  || op == OP_XOR;
  endfunction

  wire          accept = issue_valid && !busy_q;
  wire [W-1:0]  ea     = vrf[{a_q, idx_q}];
  wire [W-1:0]  eb     = vrf[{b_q, idx_q}];

  always_comb begin
    case (op_q)
      OP_ADD:  res = ea + eb;
      OP_SUB:  res = ea - eb;
      OP_AND:  res = ea & eb;
      OP_OR:   res = ea | eb;
      default: res = ea ^ eb;
    endcase
  end

  always_ff @(posedge clk) begin
    if (busy_q)
      vrf[{dst_q, idx_q}] <= res;
    else if (sc_we)
      vrf[{sc_reg, sc_idx}] <= sc_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_q <= '0;
    else        rd_q <= vrf[{sc_reg, sc_idx}];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q   <= '0;
      dst_q  <= '0;
      a_q    <= '0;
      b_q    <= '0;
      idx_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      if (busy_q) begin
        idx_q <= idx_q + IW'(1);
        if (idx_q == LAST) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end else if (accept) begin
        op_q  <= issue_op;
        dst_q <= issue_dst;
        a_q   <= issue_src_a;
        b_q   <= issue_src_b;
        idx_q <= '0;
        if (op_known(issue_op)) begin
          busy_q <= 1'b1;
        end else begin
          done_q <= 1'b1;
          err_q  <= 1'b1;
        end
      end
    end
  end

  assign issue_ready = !busy_q;
  assign busy        = busy_q;
  assign done        = done_q;
  assign err         = err_q;
  assign sc_rdata    = rd_q;

  // R4
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R4
  busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  // R4
  idx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && $past(busy_q) |-> idx_q == $past(idx_q) + IW'(1));

  // R5
  refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && issue_valid |=> $stable(dst_q) && $stable(op_q));

  // R7
  err_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> done);

  // R7
  bad_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !op_known(issue_op) |=> !busy && err);

endmodule

// File: tb/vec_seq_tb.sv
module vec_seq_tb;
  logic clk = 0;
  logic rst_n = 0;
  logic issue_valid = 0;
  logic issue_ready;
  logic [6:0] issue_op = 0;
  logic [2:0] issue_dst = 0, issue_src_a = 0, issue_src_b = 0;
  logic busy, done, err;
  logic sc_we = 0;
  logic [2:0] sc_reg = 0;
  logic [5:0] sc_idx = 0;
  logic [63:0] sc_wdata = 0;
  logic [63:0] sc_rdata;

  always #10 clk = ~clk;

  vec_seq u_dut (
    .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .issue_ready(issue_ready),
    .issue_op(issue_op), .issue_dst(issue_dst), .issue_src_a(issue_src_a),
    .issue_src_b(issue_src_b), .busy(busy), .done(done), .err(err),
    .sc_we(sc_we), .sc_reg(sc_reg), .sc_idx(sc_idx), .sc_wdata(sc_wdata),
    .sc_rdata(sc_rdata)
  );

  int tests = 0, fails = 0;
  bit finished = 0;
  logic [63:0] m [8][64];

  // op(7) dst(3) a(3) b(3)
  localparam logic [15:0] CMDS [7] = '{
    {7'h01, 3'd2, 3'd0, 3'd1},
    {7'h02, 3'd3, 3'd0, 3'd1},
    {7'h03, 3'd4, 3'd2, 3'd3},
    {7'h04, 3'd5, 3'd4, 3'd0},
    {7'h05, 3'd0, 3'd0, 3'd5},
    {7'h7F, 3'd1, 3'd0, 3'd0},
    {7'h01, 3'd6, 3'd6, 3'd6}
  };

  function automatic logic [63:0] apply(input logic [6:0] op, input logic [63:0] x, y);
    case (op)
      7'h01: return x + y;
      7'h02: return x - y;
      7'h03: return x & y;
      7'h04: return x | y;
      7'h05: return x ^ y;
      default: return x;
    endcase
  endfunction

  function automatic bit supported(input logic [6:0] op);
    return op >= 7'h01 && op <= 7'h05;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic swrite(input int r, i, input logic [63:0] v);
    @(negedge clk);
    sc_we = 1; sc_reg = 3'(r); sc_idx = 6'(i); sc_wdata = v;
    @(negedge clk);
    sc_we = 0;
    if (!busy) m[r][i] = v;
  endtask

  task automatic sread(input int r, i, output logic [63:0] v);
    @(negedge clk);
    sc_reg = 3'(r); sc_idx = 6'(i);
    @(negedge clk);
    v = sc_rdata;
  endtask

  task automatic reg_mismatch(input int r, output int bad, output logic [63:0] act, exp);
    logic [63:0] v;
    bad = 0; act = 0; exp = 0;
    for (int i = 0; i < 64; i++) begin
      sread(r, i, v);
      if (v !== m[r][i]) begin
        if (bad == 0) begin act = v; exp = m[r][i]; end
        bad++;
      end
    end
  endtask

  // Offer a command; returns at the falling edge after acceptance.
  task automatic issue(input logic [15:0] c);
    @(negedge clk);
    {issue_op, issue_dst, issue_src_a, issue_src_b} = c;
    issue_valid = 1;
    @(negedge clk);
    issue_valid = 0;
  endtask

  task automatic model_run(input logic [15:0] c);
    logic [6:0] op; logic [2:0] d, a, b;
    {op, d, a, b} = c;
    if (supported(op))
      for (int i = 0; i < 64; i++) m[d][i] = apply(op, m[a][i], m[b][i]);
  endtask

  task automatic wait_done(output int cyc);
    cyc = 0;
    while (!done && cyc < 200) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  initial begin
    int bad, cyc;
    logic [63:0] act, exp, v;
    logic [15:0] c;

    repeat (3) @(negedge clk);
    // R1
    chk(!busy && !done && !err && issue_ready && sc_rdata == 0, "R1 reset outputs",
        {busy, done, err, issue_ready}, 64'h1);
    rst_n = 1;

    for (int r = 0; r < 8; r++)
      for (int i = 0; i < 64; i++)
        swrite(r, i, (64'h9E3779B97F4A7C15 * 64'(r * 64 + i + 1)) ^ (64'(r) << 59));

    // R2
    sread(3, 17, v);
    chk(v === m[3][17], "R2 scalar readback", v, m[3][17]);
    swrite(3, 17, 64'h0123456789ABCDEF);
    sread(3, 17, v);
    chk(v === 64'h0123456789ABCDEF, "R2 scalar overwrite", v, 64'h0123456789ABCDEF);

    for (int k = 0; k < 7; k++) begin
      c = CMDS[k];
      issue(c);
      if (supported(c[15:9])) begin
        // R4
        chk(busy && !issue_ready, "R4 busy after accept", {busy, issue_ready}, 64'h2);
        wait_done(cyc);
        chk(cyc == 64, "R4 run length", 64'(cyc), 64);
        // R7 err low on supported completion
        chk(!err, "R7 err low on supported op", 64'(err), 0);
        @(negedge clk);
        chk(!done && !busy, "R4 done one cycle", {done, busy}, 0);
      end else begin
        // R7
        chk(done && err && !busy, "R7 bad op done+err", {done, err, busy}, 64'h6);
        @(negedge clk);
        chk(!done && !err, "R7 pulse one cycle", {done, err}, 0);
      end
      model_run(c);
      reg_mismatch(int'(c[8:6]), bad, act, exp);
      // R3 R6 R7 element contents
      chk(bad == 0, (k == 4 || k == 6) ? "R6 in-place result" :
                    (k == 5) ? "R7 no write" : "R3 elementwise result", act, exp);
    end

    // R3 wrap-around on add and borrow on subtract
    swrite(2, 0, 64'hFFFF_FFFF_FFFF_FFFF);
    swrite(3, 0, 64'h1);
    issue({7'h01, 3'd4, 3'd2, 3'd3});
    wait_done(cyc);
    model_run({7'h01, 3'd4, 3'd2, 3'd3});
    sread(4, 0, v);
    chk(v === 64'h0, "R3 add wraps", v, 0);
    issue({7'h02, 3'd5, 3'd3, 3'd2});
    wait_done(cyc);
    model_run({7'h02, 3'd5, 3'd3, 3'd2});
    sread(5, 0, v);
    chk(v === 64'h2, "R3 subtract borrows", v, 2);
    reg_mismatch(5, bad, act, exp);
    chk(bad == 0, "R3 subtract all elements", act, exp);

    // R5 and R8: offers during a run
    issue({7'h04, 3'd1, 3'd2, 3'd3});
    repeat (5) @(negedge clk);
    chk(!issue_ready, "R5 ready low while busy", 64'(issue_ready), 0);
    {issue_op, issue_dst, issue_src_a, issue_src_b} = {7'h03, 3'd6, 3'd0, 3'd0};
    issue_valid = 1;
    @(negedge clk);
    issue_valid = 0;
    sc_we = 1; sc_reg = 3'd7; sc_idx = 6'd5; sc_wdata = 64'hDEAD_BEEF;
    @(negedge clk);
    sc_we = 0;
    cyc = 0;
    wait_done(cyc);
    chk(cyc == 57, "R5 run not restarted", 64'(cyc), 57);
    model_run({7'h04, 3'd1, 3'd2, 3'd3});
    reg_mismatch(6, bad, act, exp);
    chk(bad == 0, "R5 refused command wrote nothing", act, exp);
    sread(7, 5, v);
    chk(v === m[7][5], "R8 scalar write ignored while busy", v, m[7][5]);
    reg_mismatch(1, bad, act, exp);
    chk(bad == 0, "R3 OR result after refused offer", act, exp);

    // R1 reset during a run
    issue({7'h01, 3'd2, 3'd0, 3'd1});
    repeat (4) @(negedge clk);
    rst_n = 0;
    @(negedge clk);
    chk(!busy && !done && !err && issue_ready && sc_rdata == 0, "R1 reset mid-run",
        {busy, done, err, issue_ready}, 64'h1);
    rst_n = 1;
    @(negedge clk);

    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      tests++; fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule